// File: doc/BRIEF.md
# Differential multi-level weight binary neuron

This block is a digital model of a single neuron column in a processing-in-memory array. Each synapse holds two unsigned multi-level cell values, one on a positive column and one on a negative column, and the signed weight of that synapse is the positive value minus the negative value. A vector of one-bit input activations acts as a set of row enables: only the synapses whose activation bit is set add their two cell values into the positive and negative column totals.

When the compare strobe is raised, the two totals and a signed offset term are combined and reduced to a single decision bit. This stands in for a sense-amplifier comparing two column currents, so the neuron's activation is a step function of its pre-activation. The offset input lets a static sense-amplifier mismatch be injected per column. Cell values are written one synapse at a time through a small load port. With a cell width of 1, 2 or 3 bits, a synapse can hold 3, 7 or 15 distinct weight levels.

Top module: `mlw_bin_neuron`

## Requirements
- R1: The signed weight of synapse i is its positive cell value minus its negative cell value. Both values are unsigned and CELL_W bits wide, and CELL_W may be 1, 2 or 3, so a weight ranges from -(2^CELL_W-1) to +(2^CELL_W-1).
- R2: When `ld_en` is high at a rising clock edge, the cell pair at index `ld_idx` takes `ld_pos` and `ld_neg`. Every other pair is unchanged, and an index of N_IN or above changes no pair.
- R3: Input i contributes to the column totals only when bit i of `act` is 1. When the bit is 0, that synapse's cells have no effect on the decision.
- R4: The decision is 1 exactly when the sum over i of act[i]*(pos_i - neg_i), plus the offset, is strictly greater than zero. A result of exactly zero gives 0.
- R5: When `cmp_go` is high at a rising edge, `fire` takes the new decision at that same edge and `fire_vld` is high for the following cycle only. Without a strobe, `fire_vld` is 0.
- R6: Between strobes, `fire` holds its last decision, whatever `act`, `ofs` or the cell contents do.
- R7: `ofs` is a two's-complement signed value of OFS_W bits and is added to the weighted sum before the sign test.
- R8: After reset, all cells read zero, and `fire` and `fire_vld` are 0.
- R9: When a load and a strobe fall on the same edge, the decision uses the cell contents from before that load.
- R10: The column totals never wrap. When every input is active and every weight is at full scale in either direction, the decision is still correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write strobe for one cell pair |
| ld_idx | input | IDX_W | Synapse index of the pair being written |
| ld_pos | input | CELL_W | Value for the positive-column cell |
| ld_neg | input | CELL_W | Value for the negative-column cell |
| act | input | N_IN | Binary input activations, one per synapse |
| cmp_go | input | 1 | Compare strobe |
| ofs | input | OFS_W | Signed offset added before the sign decision |
| fire | output | 1 | Registered binary neuron output |
| fire_vld | output | 1 | One-cycle pulse marking a fresh decision |

## Verification
A three-input, two-bit-cell configuration is swept over every activation vector, for weight sets that are fully positive, fully negative, mixed, and made of equal cell pairs. Each of these runs at offsets that span the full signed range. The full-scale sets separate a correct total from a wrapped one. The equal-pair set and the zero-offset points separate the strict tie-to-zero rule from a greater-or-equal test. A single synapse is also swept through all sixteen cell pairs, which checks the sign of each weight level on its own. Separate sequences load an out-of-range index, change the inputs without a strobe, and load and strobe on the same edge, to show which state each of these can and cannot reach.

// File: rtl/mlw_pkg.sv
package mlw_pkg;

   function automatic int cell_max(input int cell_w);
      return (1 << cell_w) - 1;
   endfunction

   function automatic int sum_bits(input int n_in, input int cell_w);
      return $clog2(n_in * cell_max(cell_w) + 1);
   endfunction

   function automatic int idx_bits(input int n_in);
      return (n_in > 1) ? $clog2(n_in) : 1;
   endfunction

endpackage

// File: rtl/mlw_pair_store.sv
module mlw_pair_store
   import mlw_pkg::*;
#(
   parameter int N_IN   = 8,
   parameter int CELL_W = 2,
   localparam int IDX_W = idx_bits(N_IN)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ld_en,
   input  logic [IDX_W-1:0]         ld_idx,
   input  logic [CELL_W-1:0]        ld_pos,
   input  logic [CELL_W-1:0]        ld_neg,
   output logic [N_IN*CELL_W-1:0]   pos_flat,
   output logic [N_IN*CELL_W-1:0]   neg_flat
);

   for (genvar i = 0; i < N_IN; i++) begin : g_cell
      logic [CELL_W-1:0] pos_q;
      logic [CELL_W-1:0] neg_q;
      logic              hit;

      assign hit = ld_en && (ld_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pos_q <= '0;
            neg_q <= '0;
         end else if (hit) begin
            pos_q <= ld_pos;
            neg_q <= ld_neg;
         end
      end

      assign pos_flat[i*CELL_W +: CELL_W] = pos_q;
      assign neg_flat[i*CELL_W +: CELL_W] = neg_q;

      AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         (ld_en && ld_idx == IDX_W'(i)) |=> (pos_flat[i*CELL_W +: CELL_W] == $past(ld_pos)
                                             && neg_flat[i*CELL_W +: CELL_W] == $past(ld_neg))); // R2
      AST_UNADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
         !(ld_en && ld_idx == IDX_W'(i)) |=> ($stable(pos_flat[i*CELL_W +: CELL_W])
                                              && $stable(neg_flat[i*CELL_W +: CELL_W]))); // R2
   end

endmodule

// File: rtl/mlw_gated_sum.sv
module mlw_gated_sum
   import mlw_pkg::*;
#(
   parameter int N_IN   = 8,
   parameter int CELL_W = 2,
   localparam int SUM_W = sum_bits(N_IN, CELL_W),
   localparam int LIM   = N_IN * cell_max(CELL_W)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_IN-1:0]          act,
   input  logic [N_IN*CELL_W-1:0]   pos_flat,
   input  logic [N_IN*CELL_W-1:0]   neg_flat,
   output logic [SUM_W-1:0]         pos_sum,
   output logic [SUM_W-1:0]         neg_sum
);

   localparam logic [SUM_W-1:0] SUM_LIM = SUM_W'(LIM);

   logic [CELL_W-1:0] gp [N_IN];
   logic [CELL_W-1:0] gn [N_IN];

   // each wordline enable gates its own pair of cells
   for (genvar i = 0; i < N_IN; i++) begin : g_lane
      assign gp[i] = act[i] ? pos_flat[i*CELL_W +: CELL_W] : '0;
      assign gn[i] = act[i] ? neg_flat[i*CELL_W +: CELL_W] : '0;
   end

   always_comb begin
      pos_sum = '0;
      neg_sum = '0;
      for (int i = 0; i < N_IN; i++) begin
         pos_sum = pos_sum + SUM_W'(gp[i]);
         neg_sum = neg_sum + SUM_W'(gn[i]);
      end
   end

   AST_SUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_sum <= SUM_LIM) && (neg_sum <= SUM_LIM)); // R10
   AST_IDLE_SUMS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (act == '0) |-> (pos_sum == '0 && neg_sum == '0)); // R3

endmodule

// File: rtl/mlw_sense_decide.sv
module mlw_sense_decide #(
   parameter int SUM_W = 5,
   parameter int OFS_W = 5,
   localparam int DW   = ((SUM_W + 1 > OFS_W) ? SUM_W + 1 : OFS_W) + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmp_go,
   input  logic [SUM_W-1:0]        pos_sum,
   input  logic [SUM_W-1:0]        neg_sum,
   input  logic [OFS_W-1:0]        ofs,
   output logic                    fire,
   output logic                    fire_vld
);

   logic signed [DW-1:0] p_s;
   logic signed [DW-1:0] n_s;
   logic signed [DW-1:0] o_s;
   logic signed [DW-1:0] pre;
   logic                 dec;

   assign p_s = $signed({{(DW-SUM_W){1'b0}}, pos_sum});
   assign n_s = $signed({{(DW-SUM_W){1'b0}}, neg_sum});
   assign o_s = $signed({{(DW-OFS_W){ofs[OFS_W-1]}}, ofs});
   assign pre = p_s - n_s + o_s;
   // strictly positive fires; an exact balance resolves low
   assign dec = !pre[DW-1] && (pre != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fire     <= 1'b0;
         fire_vld <= 1'b0;
      end else begin
         fire_vld <= cmp_go;
         if (cmp_go) fire <= dec;
      end
   end

   AST_VLD_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_go |=> fire_vld); // R5
   AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_go |=> !fire_vld); // R5
   AST_FIRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_go |=> $stable(fire)); // R6
   AST_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_go && pos_sum == neg_sum && ofs == '0) |=> !fire); // R4

endmodule

// File: rtl/mlw_bin_neuron.sv
module mlw_bin_neuron
   import mlw_pkg::*;
#(
   parameter int N_IN   = 8,
   parameter int CELL_W = 2,
   parameter int OFS_W  = 5,
   localparam int IDX_W = idx_bits(N_IN),
   localparam int SUM_W = sum_bits(N_IN, CELL_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld_en,
   input  logic [IDX_W-1:0]     ld_idx,
   input  logic [CELL_W-1:0]    ld_pos,
   input  logic [CELL_W-1:0]    ld_neg,
   input  logic [N_IN-1:0]      act,
   input  logic                 cmp_go,
   input  logic [OFS_W-1:0]     ofs,
   output logic                 fire,
   output logic                 fire_vld
);

   if (CELL_W < 1 || CELL_W > 3) begin : g_bad_cell
      $error("mlw_bin_neuron: CELL_W must be 1, 2 or 3");
   end
   if (N_IN < 1) begin : g_bad_n
      $error("mlw_bin_neuron: N_IN must be at least 1");
   end
   if (OFS_W < 2) begin : g_bad_ofs
      $error("mlw_bin_neuron: OFS_W must be at least 2");
   end

   logic [N_IN*CELL_W-1:0] pos_flat;
   logic [N_IN*CELL_W-1:0] neg_flat;
   logic [SUM_W-1:0]       pos_sum;
   logic [SUM_W-1:0]       neg_sum;

   mlw_pair_store #(.N_IN(N_IN), .CELL_W(CELL_W)) u_store (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
      .ld_pos(ld_pos), .ld_neg(ld_neg),
      .pos_flat(pos_flat), .neg_flat(neg_flat));

   mlw_gated_sum #(.N_IN(N_IN), .CELL_W(CELL_W)) u_sum (
      .clk(clk), .rst_n(rst_n), .act(act),
      .pos_flat(pos_flat), .neg_flat(neg_flat),
      .pos_sum(pos_sum), .neg_sum(neg_sum));

   mlw_sense_decide #(.SUM_W(SUM_W), .OFS_W(OFS_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go),
      .pos_sum(pos_sum), .neg_sum(neg_sum), .ofs(ofs),
      .fire(fire), .fire_vld(fire_vld));

endmodule

// File: tb/sim_mlw_bin_neuron.sv
module sim_mlw_bin_neuron;

   localparam int N  = 3;
   localparam int CW = 2;
   localparam int OW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_en = 1'b0;
   logic [1:0]    ld_idx = '0;
   logic [CW-1:0] ld_pos = '0;
   logic [CW-1:0] ld_neg = '0;
   logic [N-1:0]  act = '0;
   logic          cmp_go = 1'b0;
   logic [OW-1:0] ofs = '0;
   logic          fire;
   logic          fire_vld;

   int vec_cnt = 0;
   int err_cnt = 0;
   int cyc = 0;
   bit done = 1'b0;
   int wp [N];
   int wn [N];

   mlw_bin_neuron #(.N_IN(N), .CELL_W(CW), .OFS_W(OW)) u0 (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
      .ld_pos(ld_pos), .ld_neg(ld_neg), .act(act), .cmp_go(cmp_go),
      .ofs(ofs), .fire(fire), .fire_vld(fire_vld));

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         err_cnt++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
         $finish;
      end
   end

   task automatic chk(input logic got, input logic exp, input string req);
      if (got !== exp) begin
         err_cnt++;
         $display("FAIL %s: got %0b expected %0b", req, got, exp);
      end
   endtask

   function automatic logic model(input logic [N-1:0] a, input int o);
      int s = o;
      for (int i = 0; i < N; i++) if (a[i]) s += wp[i] - wn[i];
      return s > 0;
   endfunction

   task automatic load(input int idx, input int p, input int n);
      @(negedge clk);
      ld_en = 1'b1; ld_idx = 2'(idx); ld_pos = CW'(p); ld_neg = CW'(n);
      @(negedge clk);
      ld_en = 1'b0;
      if (idx < N) begin wp[idx] = p; wn[idx] = n; end
   endtask

   task automatic cmp(input logic [N-1:0] a, input int o, input string req);
      logic e;
      e = model(a, o);
      @(negedge clk);
      act = a; ofs = OW'(o); cmp_go = 1'b1;
      @(negedge clk);
      cmp_go = 1'b0;
      vec_cnt++;
      chk(fire_vld, 1'b1, "R5");
      chk(fire, e, req);
   endtask

   task automatic set_w(input int p0, input int n0, input int p1, input int n1,
                        input int p2, input int n2);
      load(0, p0, n0); load(1, p1, n1); load(2, p2, n2);
   endtask

   initial begin
      int ofsv [7] = '{-16, -3, -1, 0, 1, 2, 15};
      logic held;
      for (int i = 0; i < N; i++) begin wp[i] = 0; wn[i] = 0; end
      repeat (3) @(negedge clk);
      vec_cnt++; chk(fire, 1'b0, "R8"); chk(fire_vld, 1'b0, "R8");
      rst_n = 1'b1;
      // R8: cells read zero, so the decision follows the offset alone
      cmp(3'b111, 0, "R8");
      cmp(3'b111, 1, "R8");

      // R1 / R4: each single-synapse weight level, tie resolves low
      for (int p = 0; p < 4; p++)
         for (int n = 0; n < 4; n++) begin
            load(0, p, n);
            cmp(3'b001, 0, "R1");
         end

      // R3 / R4 / R7 / R10: activation and offset sweep over weight sets
      for (int s = 0; s < 5; s++) begin
         case (s)
            0: set_w(3, 0, 3, 0, 3, 0);
            1: set_w(0, 3, 0, 3, 0, 3);
            2: set_w(2, 1, 0, 3, 3, 3);
            3: set_w(1, 0, 1, 2, 3, 1);
            default: set_w(1, 1, 2, 2, 0, 0);
         endcase
         for (int a = 0; a < 8; a++)
            for (int k = 0; k < 7; k++)
               cmp(3'(a), ofsv[k], (s < 2) ? "R10" : ((k == 3) ? "R4" : "R7"));
      end

      // R2: an out-of-range index changes no pair
      set_w(0, 1, 0, 1, 0, 1);
      load(3, 3, 0);
      for (int a = 0; a < 8; a++) cmp(3'(a), 1, "R2");

      // R6 / R5: no strobe, inputs move, output holds
      cmp(3'b000, 2, "R6");
      held = fire;
      for (int j = 0; j < 4; j++) begin
         @(negedge clk);
         act = 3'(j + 1); ofs = OW'(-16);
         @(negedge clk);
         vec_cnt++;
         chk(fire, held, "R6");
         chk(fire_vld, 1'b0, "R5");
      end

      // R9: load and strobe on one edge use the old pair
      set_w(0, 0, 0, 0, 0, 0);
      @(negedge clk);
      ld_en = 1'b1; ld_idx = 2'd0; ld_pos = 2'd3; ld_neg = 2'd0;
      act = 3'b001; ofs = '0; cmp_go = 1'b1;
      @(negedge clk);
      ld_en = 1'b0; cmp_go = 1'b0;
      vec_cnt++;
      chk(fire, 1'b0, "R9");
      wp[0] = 3; wn[0] = 0;
      cmp(3'b001, 0, "R9");

      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
         $finish;
      end
   end

endmodule